// File: doc/BRIEF.md
# Load-Store Lane Formatter

This block sits between a core's 64-bit register file and a 64-bit little-endian data memory port. For each accepted request it forms the effective address from a base register and a signed 32-bit displacement. It then checks that the address is aligned for the access size. An aligned request goes to memory as one doubleword-aligned access, with per-lane byte enables. Store data is moved onto the addressed lanes. When a load's data returns, the addressed bytes are pulled out of the doubleword and extended to 64 bits. Byte and word loads are zero-extended. Longword loads are sign-extended.

A separate unaligned-quadword mode clears the three low address bits, so it always reads or writes a whole aligned doubleword and can never be misaligned. A misaligned access in normal mode issues no memory request. Instead it raises a one-cycle flag, which the surrounding trap logic can pick up. Address translation, caching and trap handling live outside this block.

Top module: `lsu_lane_fmt`

## Requirements
- R1: The effective address is `baseAddr` plus `offset` sign-extended from bit 31. One cycle after a request is accepted, `memReqValid` is high for one cycle and `memReqAddr` carries that address with bits 2:0 cleared.
- R2: `reqSize` encodes 0 = byte, 1 = word (16 bit), 2 = longword (32 bit), 3 = quadword. In normal mode an access is misaligned when the low address bits masked with 1 (word), 3 (longword) or 7 (quadword) are non-zero. A byte access is never misaligned.
- R3: For a misaligned access, `misalign` is high for exactly the one cycle after acceptance, and no memory request is issued.
- R4: With `reqUnaligned` set, the request is a quadword at the effective address with bits 2:0 cleared. `memByteEn` is 8'hFF and `misalign` stays low, whatever the size and the low address bits.
- R5: Byte lane i of the memory port is bits 8i+7:8i. A store sets `memWrite` and enables 1, 2, 4 or 8 contiguous lanes, starting at lane `addr[2:0]`. Register byte k appears on lane `addr[2:0]`+k, and all unused lanes are zero.
- R6: Byte and word loads return the addressed bytes zero-extended to 64 bits.
- R7: Longword loads return the addressed 32 bits sign-extended from their bit 31.
- R8: Quadword loads, including unaligned-mode loads, return the full doubleword unchanged.
- R9: `reqReady` is high when idle and low while a load waits for its response. On the cycle after `memRspValid`, `loadValid` is high for one cycle and `loadResult` holds the formatted data.
- R10: After reset, `reqReady` is 1 and `memReqValid`, `misalign`, `loadValid` and `loadResult` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | Access size code |
| reqUnaligned | input | 1 | Force aligned quadword access |
| baseAddr | input | 64 | Base register value |
| offset | input | 32 | Signed displacement |
| storeData | input | 64 | Register value to store |
| memReqValid | output | 1 | Memory request strobe |
| memReqAddr | output | 64 | Doubleword-aligned address |
| memWrite | output | 1 | Memory request is a write |
| memByteEn | output | 8 | Lane enables |
| memWData | output | 64 | Lane-placed write data |
| memRspValid | input | 1 | Load data returned |
| memRData | input | 64 | Returned doubleword |
| misalign | output | 1 | Misaligned access pulse |
| loadValid | output | 1 | Formatted load result valid |
| loadResult | output | 64 | Formatted load result |

## Verification
The returned doublewords are chosen so that the bytes on either side of the selected field have their top bits set. That separates zero extension from sign extension, and it shows when a wrong lane has been picked. Longword loads are run with bit 31 both set and clear. Each size is tried at several lane offsets, and a negative displacement that crosses a doubleword boundary exercises the signed address sum. Misaligned cases are paired with the same addresses in unaligned mode, which tells the alignment check apart from the address-clearing path.

// File: rtl/lsu_fmt_pkg.sv
package lsu_fmt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // register a memory request
    logic flagMis;  // raise misalign pulse
    logic capture;  // latch formatted load data
  } lsuStrobe_t;
endpackage

// File: rtl/lsu_fmt_datapath.sv
module lsu_fmt_datapath
  import lsu_fmt_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsuStrobe_t          strobe,
  input  logic                reqStore,
  input  logic [1:0]          reqSize,
  input  logic                reqUnaligned,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [OFS_W-1:0]    offset,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W-1:0]   memRData,
  output logic                misalignNow,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                memWrite,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWData,
  output logic                misalign,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] effAddr;
  accSize_e          effSize;
  logic [LANE_W-1:0] laneOff;
  logic [LANE_W-1:0] alignMask;
  logic [LANES-1:0]  laneMask;
  logic [DATA_W-1:0] dataMask;
  logic [LANE_W-1:0] savedOff;
  accSize_e          savedSize;
  logic [DATA_W-1:0] shiftedRd;
  logic [DATA_W-1:0] fmtData;

  assign effAddr = baseAddr + {{(ADDR_W-OFS_W){offset[OFS_W-1]}}, offset};
  assign effSize = reqUnaligned ? SZ_QUAD : accSize_e'(reqSize);
  assign laneOff = reqUnaligned ? '0 : effAddr[LANE_W-1:0];

  always_comb begin
    case (effSize)
      SZ_BYTE: begin alignMask = LANE_W'(0); laneMask = LANES'(8'h01); end
      SZ_WORD: begin alignMask = LANE_W'(1); laneMask = LANES'(8'h03); end
      SZ_LONG: begin alignMask = LANE_W'(3); laneMask = LANES'(8'h0F); end
      default: begin alignMask = LANE_W'(7); laneMask = LANES'(8'hFF); end
    endcase
  end

  assign misalignNow = !reqUnaligned && |(effAddr[LANE_W-1:0] & alignMask);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dataMask[8*g +: 8] = {8{laneMask[g]}};
  end

  assign shiftedRd = memRData >> {savedOff, 3'b000};

  always_comb begin
    case (savedSize)
      SZ_BYTE: fmtData = {{(DATA_W-8){1'b0}}, shiftedRd[7:0]};
      SZ_WORD: fmtData = {{(DATA_W-16){1'b0}}, shiftedRd[15:0]};
      SZ_LONG: fmtData = {{(DATA_W-32){shiftedRd[31]}}, shiftedRd[31:0]};
      default: fmtData = shiftedRd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
      memWrite    <= 1'b0;
      memByteEn   <= '0;
      memWData    <= '0;
      misalign    <= 1'b0;
      loadValid   <= 1'b0;
      loadResult  <= '0;
      savedOff    <= '0;
      savedSize   <= SZ_BYTE;
    end else begin
      memReqValid <= strobe.issue;
      misalign    <= strobe.flagMis;
      loadValid   <= strobe.capture;
      if (strobe.issue) begin
        memReqAddr <= {effAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        memWrite   <= reqStore;
        memByteEn  <= laneMask << laneOff;
        memWData   <= (storeData & dataMask) << {laneOff, 3'b000};
        savedOff   <= laneOff;
        savedSize  <= effSize;
      end
      if (strobe.capture) loadResult <= fmtData;
    end
  end
endmodule

// File: rtl/lsu_fmt_control.sv
module lsu_fmt_control
  import lsu_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqStore,
  input  logic       misalignNow,
  input  logic       memRspValid,
  output logic       reqReady,
  output lsuStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctlState_e;
  ctlState_e state;
  logic      accept;

  assign reqReady       = (state == ST_IDLE);
  assign accept         = reqValid && reqReady;
  assign strobe.issue   = accept && !misalignNow;
  assign strobe.flagMis = accept && misalignNow;
  assign strobe.capture = (state == ST_WAIT) && memRspValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobe.issue && !reqStore) state <= ST_WAIT;
        default: if (strobe.capture) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_fmt.sv
module lsu_lane_fmt
  import lsu_fmt_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqStore,
  input  logic [1:0]          reqSize,
  input  logic                reqUnaligned,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [OFS_W-1:0]    offset,
  input  logic [DATA_W-1:0]   storeData,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                memWrite,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWData,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRData,
  output logic                misalign,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult
);
  lsuStrobe_t strobe;
  logic       misalignNow;

  lsu_fmt_control ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .misalignNow(misalignNow), .memRspValid(memRspValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  lsu_fmt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqStore(reqStore),
    .reqSize(reqSize), .reqUnaligned(reqUnaligned), .baseAddr(baseAddr),
    .offset(offset), .storeData(storeData), .memRData(memRData),
    .misalignNow(misalignNow), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memWrite(memWrite), .memByteEn(memByteEn),
    .memWData(memWData), .misalign(misalign), .loadValid(loadValid),
    .loadResult(loadResult)
  );
endmodule

// File: rtl/lsu_fmt_checker.sv
module lsu_fmt_checker #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [1:0]          reqSize,
  input logic                reqUnaligned,
  input logic                memReqValid,
  input logic [ADDR_W-1:0]   memReqAddr,
  input logic                memWrite,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                memRspValid,
  input logic                misalign,
  input logic                loadValid
);
  p_addr_dw_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[2:0] == 3'b000));

  p_byte_never_mis_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSize == 2'd0) |=> !misalign);

  p_mis_no_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> !memReqValid);

  p_unal_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqUnaligned) |=> (memReqValid && memByteEn == '1 && !misalign));

  p_be_contig_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
                     $countones(memByteEn) == 4 || $countones(memByteEn) == 8));

  p_wait_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memWrite) |-> !reqReady);

  p_result_after_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memRspValid));
endmodule

bind lsu_lane_fmt lsu_fmt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/lsu_lane_fmt_tb.sv
`timescale 1ns/1ps
module lsu_lane_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqStore, reqUnaligned;
  logic [1:0]  reqSize;
  logic [63:0] baseAddr, storeData, memReqAddr, memWData, memRData, loadResult;
  logic [31:0] offset;
  logic        memReqValid, memWrite, memRspValid, misalign, loadValid;
  logic [7:0]  memByteEn;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  always #2 clk = ~clk;

  lsu_lane_fmt dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: expected load value from requirement R6/R7/R8
  function automatic logic [63:0] refLoad(input logic [63:0] rd, input int off, input int nb);
    logic [63:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = rd[8*(off+i) +: 8];
    if (nb == 4 && v[31]) v[63:32] = '1;
    return v;
  endfunction

  task automatic access(input string req, input bit st, input int sz, input bit unal,
                        input logic [63:0] base, input logic [31:0] ofs,
                        input logic [63:0] sd, input logic [63:0] rd, input int lat);
    logic [63:0] ea, expW;
    logic [7:0]  expBe;
    int nb, off;
    bit mis;
    ea  = base + {{32{ofs[31]}}, ofs};
    nb  = unal ? 8 : (1 << sz);
    off = unal ? 0 : int'(ea[2:0]);
    mis = !unal && ((int'(ea[2:0]) % nb) != 0);
    expBe = '0; expW = '0;
    for (int i = 0; i < nb; i++) begin
      expBe[off+i] = 1'b1;
      expW[8*(off+i) +: 8] = sd[8*i +: 8];
    end
    @(negedge clk);
    reqValid = 1; reqStore = st; reqSize = 2'(sz); reqUnaligned = unal;
    baseAddr = base; offset = ofs; storeData = sd;
    @(negedge clk);
    reqValid = 0;
    if (mis) begin
      chk({req, " R3 misalign"}, 64'(misalign), 64'd1);
      chk({req, " R3 no request"}, 64'(memReqValid), 64'd0);
      @(negedge clk);
      chk({req, " R3 pulse width"}, 64'(misalign), 64'd0);
      return;
    end
    chk({req, " R2 no misalign"}, 64'(misalign), 64'd0);
    chk({req, " R1 req valid"}, 64'(memReqValid), 64'd1);
    chk({req, " R1 address"}, memReqAddr, {ea[63:3], 3'b000});
    chk({req, " R5 byte enables"}, 64'(memByteEn), 64'(expBe));
    chk({req, " R5 write flag"}, 64'(memWrite), 64'(st));
    if (st) begin
      chk({req, " R5 write data"}, memWData, expW);
      @(negedge clk);
      chk({req, " R1 single request"}, 64'(memReqValid), 64'd0);
      return;
    end
    for (int c = 0; c < lat; c++) begin
      chk({req, " R9 busy"}, 64'(reqReady), 64'd0);
      @(negedge clk);
    end
    memRspValid = 1; memRData = rd;
    @(negedge clk);
    memRspValid = 0; memRData = '0;
    chk({req, " R9 load valid"}, 64'(loadValid), 64'd1);
    chk({req, " R6/R7/R8 load result"}, loadResult, refLoad(rd, off, nb));
    @(negedge clk);
    chk({req, " R9 valid width"}, 64'(loadValid), 64'd0);
    chk({req, " R9 ready again"}, 64'(reqReady), 64'd1);
  endtask

  localparam logic [63:0] PAT_HI = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] PAT_LO = 64'h1234_5678_0ABC_DEF0;
  localparam logic [63:0] SDATA  = 64'h8877_6655_4433_2211;

  initial begin
    rstN = 0; reqValid = 0; reqStore = 0; reqSize = 0; reqUnaligned = 0;
    baseAddr = '0; offset = '0; storeData = '0; memRspValid = 0; memRData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", 64'(reqReady), 64'd1);
    chk("R10 memReqValid", 64'(memReqValid), 64'd0);
    chk("R10 misalign", 64'(misalign), 64'd0);
    chk("R10 loadValid", 64'(loadValid), 64'd0);
    chk("R10 loadResult", loadResult, 64'd0);

    // R6 zero-extended byte and word loads
    access("R6 byte off5", 0, 0, 0, 64'h4000, 32'd5, '0, PAT_HI, 1);
    access("R6 byte off7", 0, 0, 0, 64'h4003, 32'd4, '0, PAT_HI, 3);
    access("R6 word off6", 0, 1, 0, 64'h4006, 32'd0, '0, PAT_HI, 2);
    // R7 sign-extended longwords, both signs
    access("R7 long neg", 0, 2, 0, 64'h4000, 32'd4, '0, PAT_HI, 1);
    access("R7 long pos", 0, 2, 0, 64'h4000, 32'd0, '0, PAT_LO, 1);
    // R8 quadword
    access("R8 quad", 0, 3, 0, 64'h7FF8, 32'd8, '0, PAT_HI, 2);
    // R1 negative displacement across a doubleword boundary
    access("R1 neg offset", 0, 0, 0, 64'h1000, 32'hFFFF_FFFD, '0, PAT_LO, 1);
    access("R1 high base", 0, 1, 0, 64'hFFFF_FFFF_0000_0010, 32'h7FFF_FFFE, '0, PAT_HI, 1);
    // R2/R3 misaligned accesses
    access("R2 word odd", 0, 1, 0, 64'h4001, 32'd0, '0, PAT_HI, 1);
    access("R2 long at 2", 1, 2, 0, 64'h4000, 32'd2, SDATA, '0, 1);
    access("R2 quad at 4", 0, 3, 0, 64'h4004, 32'd0, '0, PAT_HI, 1);
    // R4 unaligned mode at the same kinds of addresses
    access("R4 unal load", 0, 1, 1, 64'h4001, 32'd4, '0, PAT_HI, 1);
    access("R4 unal store", 1, 0, 1, 64'h4006, 32'd1, SDATA, '0, 1);
    // R5 stores of each size
    access("R5 byte store", 1, 0, 0, 64'h4003, 32'd0, SDATA, '0, 1);
    access("R5 word store", 1, 1, 0, 64'h4000, 32'd2, SDATA, '0, 1);
    access("R5 long store", 1, 2, 0, 64'h4004, 32'd0, SDATA, '0, 1);
    access("R5 quad store", 1, 3, 0, 64'h4008, 32'd0, SDATA, '0, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule